// File: doc/BRIEF.md
# Page-Translated Multi-Channel DMA Engine

This block moves data between a requesting device and a physical memory port on behalf of a small set of DMA channels. Software programs each channel through a 32-bit register bus. It sets a control word (enable and direction), a remaining byte count and a logical start address. It also fills a local page table that maps 4 KiB logical pages onto physical frames.

A device starts a transfer by presenting a channel number, a direction and a length. The engine first clears the channel's three status flags. It then refuses the request if the channel is disabled or set for the other direction. Otherwise it translates the logical address through the page table and clamps the length to the remaining count. It then issues one request on the memory port. When memory acknowledges, the count is reduced and the terminal-count flag is raised. A refusal records a memory-error flag and a per-channel NMI bit. A translation miss records an address-error flag, and no memory access is made.

Top module: `pgx_dma_engine`

## Requirements
- R1: After reset every channel register, the NMI source word, the table base and the table limit read zero, and `req_ready` is high.
- R2: Channel n's control, count and address words sit at byte offsets 0x108, 0x110 and 0x118 plus 0x20·n, and read back what was written.
- R3: Accepting a request clears control bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel before any new flag is set.
- R4: A request on a channel whose control bit 0 (enable) is clear, or whose bit 1 (1 = memory-to-device) differs from `req_to_dev`, is refused. Bit 9 is set, bit n of the NMI word at offset 0x200 is set, no memory request is made, and `done` rises with `done_ok` low.
- R5: The NMI word ignores bus writes and its bits stay set until reset.
- R6: The granted length is the smaller of `req_len` and the channel count. On memory acknowledge the count drops by that length, bit 8 is set, and `done_len` reports it.
- R7: Logical page p = addr[31:12] selects table entry p. The entry's frame word is at 0x1000+8p and its owner word at 0x1004+8p. The physical address is frame + addr[11:0].
- R8: A page whose frame is zero, whose index is at or above the table capacity, or whose index is at or above limit/8 is unmapped. It sets bit 10, leaves count and NMI unchanged, makes no memory request and ends with `done_ok` low. The refusal test of R4 takes precedence.
- R9: The table base at 0x018 stores the written value with bit 31 forced to zero. The table limit at 0x020 stores all 32 bits.
- R10: When the granted length is zero, no memory request is made, bit 8 is set and `done` rises with `done_ok` high and `done_len` zero.
- R11: `mem_req` stays high with stable address and length until `mem_ack`. `mem_we` is high for device-to-memory transfers.
- R12: `req_ready` is low from acceptance until `done`. `done` is a single-cycle pulse, two cycles after acceptance for non-memory outcomes and one cycle after `mem_ack` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Device transfer request |
| req_chan | input | 2 | Requesting channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | 16 | Requested byte count |
| req_ready | output | 1 | Engine idle, request accepted |
| done | output | 1 | Transfer outcome pulse |
| done_ok | output | 1 | Outcome was a completed transfer |
| done_len | output | 32 | Bytes moved |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access writes memory |
| mem_addr | output | 32 | Physical address |
| mem_len | output | 32 | Access length in bytes |
| mem_ack | input | 1 | Memory access complete |

## Verification
The properties assume that `mem_ack` arrives only while `mem_req` is high. They also assume that no bus write lands on the active channel's control or count word while a request is in flight. The stimulus raises `mem_ack` only after it has seen `mem_req` for a chosen number of cycles. It performs register writes only while `req_ready` is high and no request is pending.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_TODEV  = 1;
  localparam int unsigned BIT_TC     = 8;
  localparam int unsigned BIT_MERR   = 9;
  localparam int unsigned BIT_AERR   = 10;
  localparam logic [31:0] FLAG_MASK  = 32'h0000_0700;

  localparam logic [13:0] OFS_TBASE  = 14'h0018;
  localparam logic [13:0] OFS_TLIMIT = 14'h0020;
  localparam logic [13:0] OFS_NMI    = 14'h0200;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_MEM} seq_state_e;
  typedef enum logic [2:0] {EV_NONE, EV_REFUSE, EV_ADDRERR, EV_CLEAR, EV_TC} chan_ev_e;
endpackage

// File: rtl/pgx_chan_regs.sv
module pgx_chan_regs
  import pgx_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [13:0]   addr,
  input  logic [31:0]   wdata,
  input  chan_ev_e      ev,
  input  logic [CW-1:0] ev_chan,
  input  logic [31:0]   ev_len,
  input  logic [CW-1:0] sel_chan,
  output logic [31:0]   sel_ctrl,
  output logic [31:0]   sel_count,
  output logic [31:0]   sel_addr,
  output logic [NCH-1:0] nmi_vec,
  output logic [31:0]   rdata
);
  logic [NCH-1:0][31:0] ctrl_all, cnt_all, adr_all;
  logic          ch_hit;
  logic [CW-1:0] wch;
  logic [1:0]    widx;

  assign ch_hit = (addr[13:8] == 6'h01) && (32'(addr[7:5]) < NCH);
  assign wch    = addr[5+CW-1:5];
  assign widx   = addr[4:3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [31:0] ctrl_q, ctrl_d, cnt_q, cnt_d, adr_q, adr_d;
    logic        ctrl_en, cnt_en, adr_en, wsel, esel;

    assign wsel = wr_en && ch_hit && (wch == CW'(c));
    assign esel = (ev != EV_NONE) && (ev_chan == CW'(c));

    always_comb begin
      ctrl_d = ctrl_q;
      cnt_d  = cnt_q;
      adr_d  = adr_q;
      if (wsel) begin
        case (widx)
          2'd1:    ctrl_d = wdata;
          2'd2:    cnt_d  = wdata;
          2'd3:    adr_d  = wdata;
          default: ;
        endcase
      end
      if (esel) begin
        case (ev)
          EV_REFUSE:  ctrl_d = (ctrl_q & ~FLAG_MASK) | (32'd1 << BIT_MERR);
          EV_ADDRERR: ctrl_d = (ctrl_q & ~FLAG_MASK) | (32'd1 << BIT_AERR);
          EV_CLEAR:   ctrl_d = ctrl_q & ~FLAG_MASK;
          EV_TC: begin
            ctrl_d = (ctrl_q & ~FLAG_MASK) | (32'd1 << BIT_TC);
            cnt_d  = cnt_q - ev_len;
          end
          default: ;
        endcase
      end
    end

    assign ctrl_en = (wsel && widx == 2'd1) || esel;
    assign cnt_en  = (wsel && widx == 2'd2) || (esel && ev == EV_TC);
    assign adr_en  = wsel && widx == 2'd3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        cnt_q  <= '0;
        adr_q  <= '0;
      end else begin
        if (ctrl_en) ctrl_q <= ctrl_d;
        if (cnt_en)  cnt_q  <= cnt_d;
        if (adr_en)  adr_q  <= adr_d;
      end
    end

    assign ctrl_all[c] = ctrl_q;
    assign cnt_all[c]  = cnt_q;
    assign adr_all[c]  = adr_q;
  end

  logic [NCH-1:0] nmi_q, nmi_d;
  logic           nmi_en;
  assign nmi_en = (ev == EV_REFUSE);
  assign nmi_d  = nmi_q | (NCH'(1) << ev_chan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nmi_q <= '0;
    else if (nmi_en) nmi_q <= nmi_d;
  end

  assign nmi_vec   = nmi_q;
  assign sel_ctrl  = ctrl_all[sel_chan];
  assign sel_count = cnt_all[sel_chan];
  assign sel_addr  = adr_all[sel_chan];

  always_comb begin
    rdata = '0;
    if (ch_hit) begin
      case (widx)
        2'd1:    rdata = ctrl_all[wch];
        2'd2:    rdata = cnt_all[wch];
        2'd3:    rdata = adr_all[wch];
        default: rdata = '0;
      endcase
    end else if (addr == OFS_NMI) begin
      rdata = 32'(nmi_q);
    end
  end
endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat
  import pgx_pkg::*;
#(
  parameter int NPG = 16,
  localparam int IW = $clog2(NPG)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [13:0] addr,
  input  logic [31:0] wdata,
  input  logic [31:0] log_addr,
  output logic        mapped,
  output logic [31:0] phys_addr,
  output logic [31:0] rdata
);
  logic [NPG-1:0][31:0] frame_all, owner_all;
  logic          tbl_hit;
  logic [IW-1:0] ent;

  assign tbl_hit = (addr[13:12] == 2'b01) && (32'(addr[11:3]) < NPG);
  assign ent     = addr[3+IW-1:3];

  for (genvar e = 0; e < NPG; e++) begin : g_ent
    logic [31:0] frame_q, owner_q;
    logic        frame_en, owner_en;
    assign frame_en = wr_en && tbl_hit && (ent == IW'(e)) && !addr[2];
    assign owner_en = wr_en && tbl_hit && (ent == IW'(e)) &&  addr[2];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q <= '0;
        owner_q <= '0;
      end else begin
        if (frame_en) frame_q <= wdata;
        if (owner_en) owner_q <= wdata;
      end
    end
    assign frame_all[e] = frame_q;
    assign owner_all[e] = owner_q;
  end

  logic [31:0] base_q, base_d, limit_q;
  logic        base_en, limit_en;
  assign base_en  = wr_en && (addr == OFS_TBASE);
  assign limit_en = wr_en && (addr == OFS_TLIMIT);
  assign base_d   = wdata & 32'h7FFF_FFFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      if (base_en)  base_q  <= base_d;
      if (limit_en) limit_q <= wdata;
    end
  end

  logic [19:0] page;
  logic [31:0] frame_sel;
  logic        in_cap, in_lim;
  assign page      = log_addr[31:12];
  assign in_cap    = 32'(page) < NPG;
  assign in_lim    = 32'(page) < (limit_q >> 3);
  assign frame_sel = frame_all[page[IW-1:0]];
  assign mapped    = in_cap && in_lim && (frame_sel != '0);
  assign phys_addr = frame_sel + {20'h0, log_addr[11:0]};

  always_comb begin
    rdata = '0;
    if (addr == OFS_TBASE)       rdata = base_q;
    else if (addr == OFS_TLIMIT) rdata = limit_q;
    else if (tbl_hit)            rdata = addr[2] ? owner_all[ent] : frame_all[ent];
  end
endmodule

// File: rtl/pgx_seq.sv
module pgx_seq
  import pgx_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CW-1:0]    req_chan,
  input  logic             req_to_dev,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic [31:0]      sel_ctrl,
  input  logic [31:0]      sel_count,
  input  logic             xl_mapped,
  input  logic [31:0]      xl_phys,
  output logic [CW-1:0]    sel_chan,
  output chan_ev_e         ev,
  output logic [31:0]      ev_len,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_len,
  input  logic             mem_ack,
  output logic             done,
  output logic             done_ok,
  output logic [31:0]      done_len
);
  seq_state_e  st_q, st_d;
  logic [CW-1:0] chan_q;
  logic        todev_q, lat_en, clen_en;
  logic [31:0] len_q, len_d, phys_q, clen;
  logic        done_q, done_d, ok_q, ok_d;
  logic [31:0] dlen_q, dlen_d;
  logic        refuse;

  assign clen   = (len_q > sel_count) ? sel_count : len_q;
  assign refuse = !sel_ctrl[BIT_EN] || (sel_ctrl[BIT_TODEV] != todev_q);

  always_comb begin
    st_d    = st_q;
    ev      = EV_NONE;
    ev_len  = '0;
    done_d  = 1'b0;
    ok_d    = ok_q;
    dlen_d  = dlen_q;
    lat_en  = 1'b0;
    clen_en = 1'b0;
    len_d   = 32'(req_len);
    case (st_q)
      ST_IDLE: if (req_valid) begin
        lat_en = 1'b1;
        st_d   = ST_CHECK;
      end
      ST_CHECK: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        ok_d   = 1'b0;
        dlen_d = '0;
        if (refuse)          ev = EV_REFUSE;
        else if (!xl_mapped) ev = EV_ADDRERR;
        else if (clen == '0) begin
          ev   = EV_TC;
          ok_d = 1'b1;
        end else begin
          ev      = EV_CLEAR;
          done_d  = 1'b0;
          clen_en = 1'b1;
          len_d   = clen;
          st_d    = ST_MEM;
        end
      end
      ST_MEM: if (mem_ack) begin
        ev     = EV_TC;
        ev_len = len_q;
        done_d = 1'b1;
        ok_d   = 1'b1;
        dlen_d = len_q;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chan_q  <= '0;
      todev_q <= 1'b0;
      len_q   <= '0;
      phys_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      dlen_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (lat_en) begin
        chan_q  <= req_chan;
        todev_q <= req_to_dev;
      end
      if (lat_en || clen_en) len_q  <= len_d;
      if (clen_en)           phys_q <= xl_phys;
      if (done_d) begin
        ok_q   <= ok_d;
        dlen_q <= dlen_d;
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign sel_chan  = chan_q;
  assign mem_req   = (st_q == ST_MEM);
  assign mem_we    = !todev_q;
  assign mem_addr  = phys_q;
  assign mem_len   = len_q;
  assign done      = done_q;
  assign done_ok   = ok_q;
  assign done_len  = dlen_q;
endmodule

// File: rtl/pgx_dma_engine.sv
module pgx_dma_engine
  import pgx_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NPG   = 16,
  parameter int LEN_W = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [13:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [CW-1:0]    req_chan,
  input  logic             req_to_dev,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             done,
  output logic             done_ok,
  output logic [31:0]      done_len,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_len,
  input  logic             mem_ack
);
  chan_ev_e       ev;
  logic [31:0]    ev_len, sel_ctrl, sel_count, sel_addr, xl_phys;
  logic [31:0]    ch_rdata, xl_rdata;
  logic [CW-1:0]  sel_chan;
  logic           xl_mapped;
  logic [NCH-1:0] nmi_vec;

  pgx_chan_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ev(ev), .ev_chan(sel_chan), .ev_len(ev_len), .sel_chan(sel_chan),
    .sel_ctrl(sel_ctrl), .sel_count(sel_count), .sel_addr(sel_addr),
    .nmi_vec(nmi_vec), .rdata(ch_rdata)
  );

  pgx_xlat #(.NPG(NPG)) u_xlat (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .log_addr(sel_addr), .mapped(xl_mapped), .phys_addr(xl_phys), .rdata(xl_rdata)
  );

  pgx_seq #(.NCH(NCH), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_to_dev(req_to_dev), .req_len(req_len), .req_ready(req_ready),
    .sel_ctrl(sel_ctrl), .sel_count(sel_count), .xl_mapped(xl_mapped),
    .xl_phys(xl_phys), .sel_chan(sel_chan), .ev(ev), .ev_len(ev_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ack(mem_ack), .done(done), .done_ok(done_ok), .done_len(done_len)
  );

  assign reg_rdata = ch_rdata | xl_rdata;
endmodule

// File: rtl/pgx_dma_chk.sv
module pgx_dma_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           mem_req,
  input logic           mem_ack,
  input logic [31:0]    mem_addr,
  input logic [31:0]    mem_len,
  input logic           done,
  input logic           done_ok,
  input logic [NCH-1:0] nmi
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));
  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((nmi & $past(nmi)) == $past(nmi)));
  // R4
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(nmi ^ $past(nmi)) <= 1));
  // R8
  fail_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok |-> !$past(mem_req));
endmodule

bind pgx_dma_engine pgx_dma_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_len(mem_len),
  .done(done), .done_ok(done_ok), .nmi(nmi_vec)
);

// File: tb/pgx_dma_engine_test.sv
`timescale 1ns/1ps
module pgx_dma_engine_test;
  localparam int NPG = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic req_valid = 1'b0;
  logic [1:0] req_chan = '0;
  logic req_to_dev = 1'b0;
  logic [15:0] req_len = '0;
  logic req_ready, done, done_ok, mem_req, mem_we;
  logic [31:0] done_len, mem_addr, mem_len;
  logic mem_ack = 1'b0;

  int tests = 0;
  int fails = 0;

  // behavioural reference state
  int unsigned m_ctrl[4], m_cnt[4], m_adr[4], m_frame[NPG];
  int unsigned m_nmi, m_limit;

  always #10 clk = ~clk;

  pgx_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_chan(req_chan), .req_to_dev(req_to_dev), .req_len(req_len),
    .req_ready(req_ready), .done(done), .done_ok(done_ok), .done_len(done_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ack(mem_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [13:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [13:0] choff(input int ch, input int idx);
    return 14'(32'h100 + 32'h20 * ch + 8 * idx);
  endfunction

  task automatic set_chan(input int ch, input int unsigned c, input int unsigned n, input int unsigned a);
    wr(choff(ch, 1), c); wr(choff(ch, 2), n); wr(choff(ch, 3), a);
    m_ctrl[ch] = c; m_cnt[ch] = n; m_adr[ch] = a;
  endtask

  task automatic set_frame(input int p, input int unsigned f);
    wr(14'(32'h1000 + 8 * p), f);
    m_frame[p] = f;
  endtask

  // one request, checked cycle by cycle against the reference model
  task automatic do_req(input int ch, input bit td, input int len, input int delay, input string tag);
    bit refuse, mapped;
    int unsigned page, clen, phys;
    refuse = (m_ctrl[ch][0] == 1'b0) || (m_ctrl[ch][1] != td);
    page   = m_adr[ch] >> 12;
    mapped = (page < NPG) && (page < (m_limit >> 3)) && (m_frame[page % NPG] != 0);
    phys   = m_frame[page % NPG] + (m_adr[ch] & 32'hFFF);
    clen   = (len > m_cnt[ch]) ? m_cnt[ch] : len;
    @(negedge clk);
    check({tag, " R12 ready before"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_chan = 2'(ch); req_to_dev = td; req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R12 busy"}, 32'(req_ready), 0);
    check({tag, " R11 no early mem"}, 32'(mem_req), 0);
    @(negedge clk);
    m_ctrl[ch] = m_ctrl[ch] & ~32'h700;   // R3
    if (refuse || !mapped || clen == 0) begin
      check({tag, " R4/R8/R10 no mem"}, 32'(mem_req), 0);
      check({tag, " R12 done"}, 32'(done), 1);
      check({tag, " done_ok"}, 32'(done_ok), (!refuse && mapped) ? 1 : 0);
      if (refuse) begin
        m_ctrl[ch] |= 32'h200; m_nmi |= (1 << ch);
      end else if (!mapped) begin
        m_ctrl[ch] |= 32'h400;
      end else begin
        m_ctrl[ch] |= 32'h100;
        check({tag, " R10 len0"}, done_len, 0);
      end
    end else begin
      check({tag, " R11 mem_req"}, 32'(mem_req), 1);
      check({tag, " R7 phys"}, mem_addr, phys);
      check({tag, " R6 clamp"}, mem_len, clen);
      check({tag, " R11 we"}, 32'(mem_we), td ? 0 : 1);
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        check({tag, " R11 hold"}, {31'b0, mem_req}, 1);
        check({tag, " R11 addr stable"}, mem_addr, phys);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      check({tag, " R6 done"}, 32'(done), 1);
      check({tag, " R6 ok"}, 32'(done_ok), 1);
      check({tag, " R6 done_len"}, done_len, clen);
      check({tag, " R11 mem released"}, 32'(mem_req), 0);
      m_ctrl[ch] |= 32'h100;
      m_cnt[ch] -= clen;
    end
    @(negedge clk);
    check({tag, " R12 pulse"}, 32'(done), 0);
    rd_check({tag, " ctrl"}, choff(ch, 1), m_ctrl[ch]);
    rd_check({tag, " count"}, choff(ch, 2), m_cnt[ch]);
    rd_check({tag, " nmi"}, 14'h200, m_nmi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (m_frame[i]) m_frame[i] = 0;
    for (int c = 0; c < 4; c++) begin m_ctrl[c] = 0; m_cnt[c] = 0; m_adr[c] = 0; end
    m_nmi = 0; m_limit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ready", 32'(req_ready), 1);
    for (int c = 0; c < 4; c++)
      for (int k = 1; k < 4; k++) rd_check("R1 chan reg", choff(c, k), 0);
    rd_check("R1 nmi", 14'h200, 0);
    rd_check("R1 limit", 14'h020, 0);
    rd_check("R1 base", 14'h018, 0);
    // R9 base mask, limit full
    wr(14'h018, 32'hFFFF_F000);
    rd_check("R9 base", 14'h018, 32'h7FFF_F000);
    wr(14'h020, 32'h80);  m_limit = 32'h80;
    rd_check("R9 limit", 14'h020, 32'h80);
    // R7 table
    set_frame(1, 32'h0004_0000);
    set_frame(2, 32'h0009_3000);
    wr(14'h100C, 32'h0000_ABCD);
    rd_check("R7 owner", 14'h100C, 32'h0000_ABCD);
    rd_check("R7 frame", 14'h1008, 32'h0004_0000);
    // R2 layout
    set_chan(3, 32'h0000_0701, 32'h1234, 32'h0000_5678);
    rd_check("R2 ctrl", 14'h168, 32'h701);
    rd_check("R2 count", 14'h170, 32'h1234);
    rd_check("R2 addr", 14'h178, 32'h5678);
    // R3 R6 R7 R11 device-to-memory with stale flags
    set_chan(0, 32'h0000_0701, 100, 32'h0000_1010);
    do_req(0, 1'b0, 40, 2, "R3 R6 d2m");
    do_req(0, 1'b0, 100, 0, "R6 clamp");
    do_req(0, 1'b0, 8, 0, "R10 zero");
    // R4 disabled, then direction mismatch
    set_chan(1, 0, 50, 32'h1000);
    do_req(1, 1'b0, 4, 0, "R4 disabled");
    set_chan(2, 32'h3, 16, 32'h0000_2004);
    do_req(2, 1'b0, 4, 0, "R4 dir");
    // R5 nmi read-only
    wr(14'h200, 32'h0);
    rd_check("R5 nmi ro", 14'h200, m_nmi);
    // R11 memory-to-device
    do_req(2, 1'b1, 64, 3, "R11 m2d");
    // R8 unmapped: zero frame, beyond capacity, beyond limit
    set_chan(3, 32'h1, 32, 32'h0000_3000);
    do_req(3, 1'b0, 4, 0, "R8 zero frame");
    set_chan(3, 32'h1, 32, 32'h0002_0000);
    do_req(3, 1'b0, 4, 0, "R8 capacity");
    wr(14'h020, 32'h10); m_limit = 32'h10;
    set_chan(3, 32'h1, 32, 32'h0000_2000);
    do_req(3, 1'b0, 4, 0, "R8 limit");
    set_chan(3, 32'h1, 32, 32'h0000_1FF0);
    do_req(3, 1'b0, 8, 1, "R7 inside limit");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule